// File: doc/BRIEF.md
# Two-Thread Shared Translation Buffer

This block is a small fully associative translation cache that two hardware threads of one core use together. Each cycle it can take one lookup, one fill and one flush. A lookup carries a thread number, a virtual page number and a context identifier. One cycle later the block answers with hit or miss and, on a hit, the physical page number. Fills come from an outside page walker. A flush marks an address-space switch by one thread.

Two inputs set how the entries are tagged and shared. When context tagging is off, each entry records the one-bit number of the thread that filled it. A flush then removes only that thread's entries. When context tagging is on, entries are matched and flushed by their context identifier, and the thread number plays no part in matching. The other input chooses the sharing policy. In shared mode any entry can serve either thread, so one thread can evict the other's translations. In partitioned mode each thread has its own half of the array.

Top module: `smt_tlb`

## Requirements
- R1: After reset every entry is invalid, so the first lookup misses.
- R2: A lookup presented in cycle t gives `rsp_valid` high in cycle t+1. `rsp_valid` is low in any cycle that follows a cycle with no lookup. A miss reports `rsp_ppn` as zero.
- R3: With context tagging off and shared mode on, a lookup hits only if the virtual page matches and the entry's stored thread bit equals `lk_tid`.
- R4: With context tagging off, a flush invalidates every entry whose thread bit equals `flush_tid`. Entries of the other thread stay valid.
- R5: With context tagging on, a lookup matches on the virtual page and on the context identifier. The thread bit is ignored.
- R6: With context tagging on, a flush invalidates only the entries whose context identifier equals `flush_pcid`, whatever the thread.
- R7: In shared mode a fill takes the lowest-numbered invalid entry. If there is none, it takes the entry at a round-robin pointer that covers the whole array. The pointer advances only when it is used.
- R8: In partitioned mode, thread 0 owns entries 0 to ENTRIES/2-1 and thread 1 owns the upper half. Each thread fills and looks up only in its own half, using the same invalid-first rule and a separate round-robin pointer per half.
- R9: When a flush and a fill arrive in the same cycle, the flush acts first, so the new entry survives even if it belongs to the flushing thread.
- R10: A fill that matches a valid entry, using the same matching rule as a lookup, overwrites that entry instead of adding a duplicate.
- R11: A lookup sees the array as it stood before the fill and flush of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| part_mode | input | 1 | 1 = each thread owns half the entries, 0 = shared |
| pcid_en | input | 1 | 1 = match and flush by context identifier |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | 1 | Requesting thread |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_pcid | input | 12 | Context identifier of the lookup |
| fill_valid | input | 1 | Write a translation |
| fill_tid | input | 1 | Thread that owns the fill |
| fill_vpn | input | 36 | Virtual page number of the fill |
| fill_pcid | input | 12 | Context identifier of the fill |
| fill_ppn | input | 28 | Physical page number of the fill |
| flush_valid | input | 1 | Address-space switch event |
| flush_tid | input | 1 | Thread switching address space |
| flush_pcid | input | 12 | Context to drop when context tagging is on |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 28 | Translated physical page, zero on miss |

## Verification
The bound checker watches these properties on every cycle:
- the one-cycle response timing and the zero page number on a miss;
- the empty array after reset;
- the absence, after a thread flush, of valid entries carrying the flushed thread bit, unless a fill for that thread came in the same cycle;
- that a fill never lowers the number of valid entries;
- that a partitioned fill from thread 0 leaves the upper half alone.

Some behaviour only the bench's scenarios, checked against its reference model, can show. This covers which entry the round-robin pointer picks, which translations survive eviction by the other thread, the context-based hits and flushes, the overwrite of a matching entry, and the old-state view of a lookup that coincides with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 36;
    parameter int PPN_W  = 28;
    parameter int PCID_W = 12;

    typedef struct packed {
        logic              valid;
        logic              tid;
        logic [PCID_W-1:0] pcid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t [N-1:0]      ents,
    input  logic       [N-1:0]      region,
    input  logic                    pcid_en,
    input  logic                    part_mode,
    input  logic                    tid,
    input  logic       [VPN_W-1:0]  vpn,
    input  logic       [PCID_W-1:0] pcid,
    output logic       [N-1:0]      match
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic tag_ok;
        assign tag_ok   = pcid_en ? (ents[g].pcid == pcid)
                                  : (part_mode | (ents[g].tid == tid));
        assign match[g] = ents[g].valid & region[g] & (ents[g].vpn == vpn) & tag_ok;
    end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/smt_tlb.sv
module smt_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_mode,
    input  logic              pcid_en,
    input  logic              lk_valid,
    input  logic              lk_tid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PCID_W-1:0] lk_pcid,
    input  logic              fill_valid,
    input  logic              fill_tid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PCID_W-1:0] fill_pcid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              flush_valid,
    input  logic              flush_tid,
    input  logic [PCID_W-1:0] flush_pcid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int HALF_W = IDX_W - 1;

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0]    ent;
        logic       [IDX_W-1:0]      rr_all;
        logic       [1:0][HALF_W-1:0] rr_half;
        logic                        rsp_v;
        logic                        rsp_hit;
        logic       [PPN_W-1:0]      rsp_ppn;
    } state_t;

    state_t st_d, st_q;

    // Region masks: all entries when shared, the thread's half when partitioned
    logic [ENTRIES-1:0] lk_region, fill_region;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_region
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        assign lk_region[g]   = ~part_mode | (GI[IDX_W-1] == lk_tid);
        assign fill_region[g] = ~part_mode | (GI[IDX_W-1] == fill_tid);
    end

    // Flush stage: applied before the fill of the same cycle
    tlb_entry_t [ENTRIES-1:0] ent_fl;
    logic       [ENTRIES-1:0] free_vec;
    always_comb begin
        ent_fl = st_q.ent;
        for (int i = 0; i < ENTRIES; i++) begin
            if (flush_valid && ent_fl[i].valid &&
                (pcid_en ? (ent_fl[i].pcid == flush_pcid) : (ent_fl[i].tid == flush_tid)))
                ent_fl[i].valid = 1'b0;
            free_vec[i] = ~ent_fl[i].valid & fill_region[i];
        end
    end

    logic [ENTRIES-1:0] lk_match, fill_match;
    logic               lk_any, fm_any, fr_any;
    logic [IDX_W-1:0]   lk_idx, fm_idx, fr_idx;

    tlb_cam #(.N(ENTRIES)) u_lk_cam (
        .ents(st_q.ent), .region(lk_region), .pcid_en(pcid_en), .part_mode(part_mode),
        .tid(lk_tid), .vpn(lk_vpn), .pcid(lk_pcid), .match(lk_match)
    );
    tlb_cam #(.N(ENTRIES)) u_fill_cam (
        .ents(ent_fl), .region(fill_region), .pcid_en(pcid_en), .part_mode(part_mode),
        .tid(fill_tid), .vpn(fill_vpn), .pcid(fill_pcid), .match(fill_match)
    );
    tlb_prio #(.N(ENTRIES)) u_lk_prio   (.req(lk_match),   .any(lk_any), .idx(lk_idx));
    tlb_prio #(.N(ENTRIES)) u_fill_prio (.req(fill_match), .any(fm_any), .idx(fm_idx));
    tlb_prio #(.N(ENTRIES)) u_free_prio (.req(free_vec),   .any(fr_any), .idx(fr_idx));

    always_comb begin
        logic [IDX_W-1:0] wr_idx;
        wr_idx = '0;
        st_d   = st_q;

        st_d.rsp_v   = lk_valid;
        st_d.rsp_hit = lk_valid & lk_any;
        st_d.rsp_ppn = (lk_valid & lk_any) ? st_q.ent[lk_idx].ppn : '0;

        st_d.ent = ent_fl;
        if (fill_valid) begin
            if (fm_any) begin
                wr_idx = fm_idx;
            end else if (fr_any) begin
                wr_idx = fr_idx;
            end else if (part_mode) begin
                wr_idx = {fill_tid, st_q.rr_half[fill_tid]};
                st_d.rr_half[fill_tid] = st_q.rr_half[fill_tid] + 1'b1;
            end else begin
                wr_idx = st_q.rr_all;
                st_d.rr_all = st_q.rr_all + 1'b1;
            end
            st_d.ent[wr_idx].valid = 1'b1;
            st_d.ent[wr_idx].tid   = fill_tid;
            st_d.ent[wr_idx].pcid  = fill_pcid;
            st_d.ent[wr_idx].vpn   = fill_vpn;
            st_d.ent[wr_idx].ppn   = fill_ppn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_ppn   = st_q.rsp_ppn;

    // Observation vectors for the bound checker
    logic [ENTRIES-1:0] vld_vec, tid_vec;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i] = st_q.ent[i].valid;
            tid_vec[i] = st_q.ent[i].tid;
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             part_mode,
    input logic             pcid_en,
    input logic             lk_valid,
    input logic             fill_valid,
    input logic             fill_tid,
    input logic             flush_valid,
    input logic             flush_tid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic [N-1:0]     vld_vec,
    input logic [N-1:0]     tid_vec
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_vec == '0)); // R1
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0)); // R2
    AST_FLUSH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !pcid_en && !(fill_valid && fill_tid == flush_tid))
        |=> ((vld_vec & ($past(flush_tid) ? tid_vec : ~tid_vec)) == '0)); // R4
    AST_FILL_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_valid) |=> ($countones(vld_vec) >= $past($countones(vld_vec)))); // R10
    AST_PART_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (part_mode && fill_valid && !fill_tid && !flush_valid)
        |=> $stable(vld_vec[N-1:N/2])); // R8
endmodule

bind smt_tlb tlb_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .part_mode(part_mode), .pcid_en(pcid_en),
    .lk_valid(lk_valid), .fill_valid(fill_valid), .fill_tid(fill_tid),
    .flush_valid(flush_valid), .flush_tid(flush_tid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .vld_vec(vld_vec), .tid_vec(tid_vec)
);

// File: tb/sim_smt_tlb.sv
module sim_smt_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        part_mode = 1'b0, pcid_en = 1'b0;
    logic        lk_valid = 1'b0, lk_tid = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic [11:0] lk_pcid = '0;
    logic        fill_valid = 1'b0, fill_tid = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [11:0] fill_pcid = '0;
    logic [27:0] fill_ppn = '0;
    logic        flush_valid = 1'b0, flush_tid = 1'b0;
    logic [11:0] flush_pcid = '0;
    logic        rsp_valid, rsp_hit;
    logic [27:0] rsp_ppn;

    always #10 clk = ~clk; // 50 MHz

    smt_tlb u0 (.*);

    // Reference model
    bit        mv[16];
    bit        mt[16];
    bit [11:0] mp[16];
    bit [35:0] mvpn[16];
    bit [27:0] mppn[16];
    int        rr_all = 0;
    int        rr_h[2] = '{0, 0};

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    function automatic bit in_reg(int i, bit t);
        return !part_mode || ((i / 8) == t);
    endfunction

    function automatic bit m_match(int i, bit t, bit [35:0] v, bit [11:0] p);
        if (!mv[i] || !in_reg(i, t) || mvpn[i] != v) return 0;
        if (pcid_en) return mp[i] == p;
        return part_mode || (mt[i] == t);
    endfunction

    task automatic tick();
        bit        ev, eh;
        bit [27:0] ep;
        int        w;
        @(posedge clk);
        ev = lk_valid; eh = 0; ep = '0;
        if (lk_valid)
            for (int i = 0; i < 16; i++)
                if (!eh && m_match(i, lk_tid, lk_vpn, lk_pcid)) begin eh = 1; ep = mppn[i]; end
        if (flush_valid)
            for (int i = 0; i < 16; i++)
                if (pcid_en ? (mp[i] == flush_pcid) : (mt[i] == flush_tid)) mv[i] = 0;
        if (fill_valid) begin
            w = -1;
            for (int i = 0; i < 16; i++) if (w < 0 && m_match(i, fill_tid, fill_vpn, fill_pcid)) w = i;
            for (int i = 0; i < 16; i++) if (w < 0 && !mv[i] && in_reg(i, fill_tid)) w = i;
            if (w < 0) begin
                if (part_mode) begin
                    w = fill_tid * 8 + rr_h[fill_tid];
                    rr_h[fill_tid] = (rr_h[fill_tid] + 1) % 8;
                end else begin
                    w = rr_all; rr_all = (rr_all + 1) % 16;
                end
            end
            mv[w] = 1; mt[w] = fill_tid; mp[w] = fill_pcid; mvpn[w] = fill_vpn; mppn[w] = fill_ppn;
        end
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== ev || (ev && (rsp_hit !== eh || rsp_ppn !== ep))) begin
            n_bad++;
            $display("FAIL %s: v/hit/ppn actual %0b/%0b/%h expected %0b/%0b/%h",
                     cur_req, rsp_valid, rsp_hit, rsp_ppn, ev, eh, ep);
        end
        lk_valid = 0; fill_valid = 0; flush_valid = 0;
    endtask

    task automatic look(bit t, bit [35:0] v, bit [11:0] p = 0);
        lk_valid = 1; lk_tid = t; lk_vpn = v; lk_pcid = p;
    endtask
    task automatic fill(bit t, bit [35:0] v, bit [27:0] pp, bit [11:0] p = 0);
        fill_valid = 1; fill_tid = t; fill_vpn = v; fill_ppn = pp; fill_pcid = p;
    endtask
    task automatic flush(bit t, bit [11:0] p = 0);
        flush_valid = 1; flush_tid = t; flush_pcid = p;
    endtask

    initial begin
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog: cycles actual %0d expected below 20000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; look(0, 5); tick(); tick(); // R2 idle cycle checked too
        cur_req = "R3";
        fill(0, 'h100, 'hA); tick();
        look(0, 'h100); tick();
        look(1, 'h100); tick();
        fill(1, 'h100, 'hB); tick();
        look(1, 'h100); tick();
        look(0, 'h100); tick();
        cur_req = "R11";
        fill(0, 'h200, 'h22); look(0, 'h200); tick();
        look(0, 'h200); tick();
        cur_req = "R10";
        fill(0, 'h100, 'hC); tick();
        look(0, 'h100); tick();
        cur_req = "R4";
        flush(0); tick();
        look(0, 'h100); tick();
        look(1, 'h100); tick();
        cur_req = "R9";
        flush(1); fill(1, 'h300, 'h33); tick();
        look(1, 'h300); tick();
        look(1, 'h100); tick();
        cur_req = "R7";
        flush(0); tick(); flush(1); tick();
        for (int i = 0; i < 16; i++) begin fill(0, 'h1000 + i, 'h100 + i); tick(); end
        for (int i = 0; i < 3; i++) begin fill(1, 'h2000 + i, 'h200 + i); tick(); end
        look(0, 'h1000); tick();
        look(0, 'h1003); tick();
        look(1, 'h2001); tick();
        cur_req = "R8";
        flush(0); tick(); flush(1); tick();
        part_mode = 1;
        for (int i = 0; i < 3; i++) begin fill(1, 'h5000 + i, 'h500 + i); tick(); end
        for (int i = 0; i < 12; i++) begin fill(0, 'h4000 + i, 'h400 + i); tick(); end
        for (int i = 0; i < 12; i++) begin look(0, 'h4000 + i); tick(); end
        for (int i = 0; i < 3; i++) begin look(1, 'h5000 + i); tick(); end
        look(1, 'h4008); tick();
        cur_req = "R5";
        part_mode = 0; pcid_en = 1;
        fill(0, 'h700, 'h70, 5); tick();
        look(1, 'h700, 5); tick();
        look(0, 'h700, 6); tick();
        cur_req = "R6";
        fill(1, 'h701, 'h71, 6); tick();
        flush(1, 5); tick();
        look(0, 'h700, 5); tick();
        look(1, 'h701, 6); tick();
        cur_req = "R3";
        for (int i = 0; i < 600; i++) begin
            if (i % 60 == 0) begin part_mode = $urandom_range(0, 1); pcid_en = $urandom_range(0, 1); end
            if ($urandom_range(0, 1)) look($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1));
            if ($urandom_range(0, 2) != 0) fill($urandom_range(0, 1), $urandom_range(0, 7), $urandom, $urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0) flush($urandom_range(0, 1), $urandom_range(0, 1));
            tick();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule